// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave with Fill-All Write

This block models the slave side of a three-wire serial EEPROM whose 64 x 16 array is held in registers. A host selects it with a chip-select line, shifts instructions and data in on a serial data line on the rising edges of a serial clock, and reads results or status back on a serial output that the block drives only when it has something to say. The serial lines are sampled by a faster system clock, so their edges are seen one system clock after they occur.

Four instructions are understood. There is a command that arms writes, one that disarms them, a fill-all write that loads one 16-bit value into every word, and a plain word read. The fill-all write starts a self-timed cycle of a parameterised number of system clocks. That cycle first erases the whole array and then programs the new value. While the cycle runs, the block turns away every new instruction. A host that raises chip select while idle sees the state of the cycle on the serial output. A parameter decides which event starts the cycle: the serial clock edge that takes in the last data bit, or the chip-select fall that follows that bit.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high, the block samples `di` on each rising edge of `sck`. Zeros received before the first 1 are discarded. That first 1 is the start bit, and it is followed by a 2-bit opcode and then a 6-bit address, each sent most significant bit first.
- R2: Opcode 00 with address bits [5:4] = 11 arms writes. Opcode 00 with address bits [5:4] = 00 disarms them. Writes are disarmed after reset.
- R3: Opcode 00 with address bits [5:4] = 01, followed by 16 data bits sent MSB first, is the fill-all write. Once its self-timed cycle ends, every word of the array holds that 16-bit value.
- R4: A fill-all write received while writes are disarmed has no effect. No cycle starts, no status is shown, and the array keeps its contents.
- R5: With `CS_START` = 0, the self-timed cycle starts on the `sck` rising edge that samples the last data bit. With `CS_START` = 1, it starts on the fall of chip select that follows that bit.
- R6: The cycle lasts `CYCLE_LEN` system clocks and needs no `sck` edges. Any instruction that arrives during the cycle, including arm or disarm, is ignored.
- R7: After a fill-all write has started, raising chip select while no instruction is being shifted makes `do_oe` high. `do_o` then reads 0 while the cycle runs and 1 once it has ended.
- R8: A start bit received after the cycle ends clears the status indication. After that, chip select going low and then high again leaves `do_oe` low.
- R9: `do_oe` is low while chip select is low, while an instruction or data word is being shifted in, and after reset.
- R10: Opcode 10 reads the word at the 6-bit address. From the edge that samples the last address bit, `do_o` drives a dummy 0. Each further `sck` rising edge then presents the next bit of the word, MSB first. The array resets to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data or ready/busy status out |
| do_oe | output | 1 | Output enable for `do_o`; when low the pin is high impedance |

## Verification
The fill-all write is tried in four ways: with writes armed, with writes disarmed, preceded by leading zeros, and overlapped by an arm/disarm command sent during the cycle. Together these separate the effect of the enable latch, start-bit hunting and the rule that busy time refuses instructions. Words at the bottom, middle and top addresses are read back, which shows that the whole array is filled and not just one location. A second instance uses the other start-event setting and receives the same stimulus with chip select held high after the last bit, so its later ready time tells the two start events apart. A reference model that runs alongside the design predicts `do_oe` and `do_o` on every clock.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int CYCLE_LEN = 40,
  parameter bit CS_START  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int WORDS = 1 << AW;
  localparam int CMDW  = AW + 2;
  localparam int MAXB  = (CMDW > DW) ? CMDW : DW;
  localparam int NW    = $clog2(MAXB + 1);
  localparam int TW    = $clog2(CYCLE_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_RD, S_DONE} st_t;

  st_t             st;
  logic            cs_q, sck_q, wen, busy, stat, pend;
  logic [NW-1:0]   cnt;
  logic [TW-1:0]   tmr;
  logic [CMDW-1:0] sh;
  logic [DW-1:0]   dsh, wdata;
  logic [DW:0]     rd_sh;
  logic [DW-1:0]   mem [WORDS];

  wire             sck_rise = cs && sck && !sck_q;
  wire             cs_fall  = !cs && cs_q;
  wire [CMDW-1:0]  cmd_nx   = {sh[CMDW-2:0], di};
  wire [DW-1:0]    dat_nx   = {dsh[DW-2:0], di};
  wire             last_dat = sck_rise && st == S_DATA && cnt == NW'(DW - 1);
  wire             go       = (!CS_START && last_dat && wen) || (cs_fall && pend);

  assign do_oe = cs_q && ((st == S_IDLE && stat) || st == S_RD);
  assign do_o  = (st == S_RD) ? rd_sh[DW] : !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
      wen   <= 1'b0;
      busy  <= 1'b0;
      stat  <= 1'b0;
      pend  <= 1'b0;
      cnt   <= '0;
      tmr   <= '0;
      sh    <= '0;
      dsh   <= '0;
      wdata <= '0;
      rd_sh <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      cs_q  <= cs;
      sck_q <= sck;
      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          for (int i = 0; i < WORDS; i++) mem[i] <= wdata;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (go) begin
        busy <= 1'b1;
        tmr  <= TW'(CYCLE_LEN - 1);
        stat <= 1'b1;
        pend <= 1'b0;
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      end
      if (cs_fall) begin
        st <= S_IDLE;
      end else if (sck_rise) begin
        case (st)
          S_IDLE: if (di && !busy) begin
            st   <= S_CMD;
            cnt  <= '0;
            stat <= 1'b0;
          end
          S_CMD: begin
            sh  <= cmd_nx;
            cnt <= cnt + 1'b1;
            if (cnt == NW'(CMDW - 1)) begin
              st <= S_DONE;
              if (cmd_nx[CMDW-1 -: 2] == 2'b10) begin
                st    <= S_RD;
                rd_sh <= {1'b0, mem[cmd_nx[AW-1:0]]};
              end else if (cmd_nx[CMDW-1 -: 2] == 2'b00) begin
                case (cmd_nx[AW-1 -: 2])
                  2'b11:   wen <= 1'b1;
                  2'b00:   wen <= 1'b0;
                  2'b01: begin
                    st  <= S_DATA;
                    cnt <= '0;
                  end
                  default: ;
                endcase
              end
            end
          end
          S_DATA: begin
            dsh <= dat_nx;
            cnt <= cnt + 1'b1;
            if (cnt == NW'(DW - 1)) begin
              st <= S_DONE;
              if (wen) begin
                wdata <= dat_nx;
                if (CS_START) pend <= 1'b1;
              end
            end
          end
          S_RD:    rd_sh <= {rd_sh[DW-1:0], 1'b0};
          default: ;
        endcase
      end
    end
  end

  // R9
  dout_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe);

  // R9
  dout_off_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD || st == S_DATA) |-> !do_oe);

  // R4
  cycle_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  // R6
  enable_frozen_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wen));

  // R7
  status_low_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe && st == S_IDLE) |-> !do_o);

  // R3
  array_uniform_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mem[0] == mem[WORDS-1] && mem[WORDS/2] == mem[0]));
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic do_o, do_oe, do2, oe2;
  int   n_cmp = 0, n_bad = 0;
  string req = "R9";
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom #(.CYCLE_LEN(CYC), .CS_START(1'b0)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .do_o(do_o), .do_oe(do_oe));
  mw_eeprom #(.CYCLE_LEN(CYC), .CS_START(1'b1)) u_mw_eeprom_cs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .do_o(do2), .do_oe(oe2));

  // reference model of the clock-started instance
  int m_mem [64];
  int m_state, m_wen, m_busy, m_tmr, m_stat, m_csq, m_sckq, m_wd, m_wdata, m_nd;
  bit m_q [$];
  bit m_rq [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      m_state = 0; m_wen = 0; m_busy = 0; m_tmr = 0; m_stat = 0;
      m_csq = 0; m_sckq = 0; m_wd = 0; m_wdata = 0; m_nd = 0;
      m_q.delete(); m_rq.delete();
    end else begin
      int op, at, ad;
      if (m_busy != 0) begin
        if (m_tmr == 0) begin
          m_busy = 0;
          foreach (m_mem[i]) m_mem[i] = m_wdata;
        end else m_tmr--;
      end
      if (!cs && m_csq != 0) m_state = 0;
      else if (cs && sck && m_sckq == 0) begin
        if (m_state == 0) begin
          if (di && m_busy == 0) begin m_state = 1; m_q.delete(); m_stat = 0; end
        end else if (m_state == 1) begin
          m_q.push_back(di);
          if (m_q.size() == 8) begin
            op = m_q[0] * 2 + m_q[1];
            at = m_q[2] * 2 + m_q[3];
            ad = 0;
            for (int k = 2; k < 8; k++) ad = ad * 2 + m_q[k];
            m_state = 4;
            if (op == 2) begin
              m_state = 3; m_rq.delete(); m_rq.push_back(1'b0);
              for (int k = 15; k >= 0; k--) m_rq.push_back(m_mem[ad][k]);
            end else if (op == 0) begin
              if (at == 3) m_wen = 1;
              else if (at == 0) m_wen = 0;
              else if (at == 1) begin m_state = 2; m_wd = 0; m_nd = 0; end
            end
          end
        end else if (m_state == 2) begin
          m_wd = ((m_wd << 1) | di) & 16'hFFFF; m_nd++;
          if (m_nd == 16) begin
            m_state = 4;
            if (m_wen != 0) begin
              m_wdata = m_wd; m_busy = 1; m_tmr = CYC - 1; m_stat = 1;
              foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            end
          end
        end else if (m_state == 3) begin
          if (m_rq.size() > 0) void'(m_rq.pop_front());
        end
      end
      m_csq = cs; m_sckq = sck;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit eoe, edo;
    eoe = (m_csq != 0) && ((m_state == 0 && m_stat != 0) || m_state == 3);
    edo = (m_state == 3) ? ((m_rq.size() > 0) ? m_rq[0] : 1'b0) : (m_busy == 0);
    n_cmp++;
    if (do_oe !== eoe) begin
      n_bad++; $display("FAIL %s: do_oe=%0b expected %0b at %0t", req, do_oe, eoe, $time);
    end else if (eoe && do_o !== edo) begin
      n_bad++; $display("FAIL %s: do_o=%0b expected %0b at %0t", req, do_o, edo, $time);
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); di = b; sck = 1'b0;
    tick(1);
    @(negedge clk); sck = 1'b1;
    tick(1);
  endtask

  task automatic send(input int nb, input logic [31:0] v);
    for (int i = nb - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic set_cs(input bit b);
    @(negedge clk); cs = b; sck = 1'b0;
  endtask

  task automatic cmd(input logic [8:0] c);
    set_cs(1); send(9, c); set_cs(0);
  endtask

  task automatic wral(input logic [15:0] d);
    set_cs(1); send(9, 9'b1_00_010000); send(16, d);
  endtask

  task automatic rd_word(input int a, output logic [15:0] w);
    set_cs(1); send(9, {3'b1_10, a[5:0]});
    chk("R10 dummy bit", {do_oe, do_o}, 2'b10);
    for (int i = 15; i >= 0; i--) begin send_bit(1'b0); w[i] = do_o; end
    set_cs(0);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (do_o !== 1'b1 && n < 500) begin tick(1); n++; end
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: run did not end, expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int n, n1, n2;
    tick(3); rst_n = 1'b1; tick(2);
    chk("R9 reset oe", do_oe, 0);
    req = "R10"; rd_word(0, w); chk("R10 reset word", w, 16'hFFFF);

    req = "R4"; wral(16'h5555); set_cs(0); set_cs(1); tick(3);
    chk("R4 no status", do_oe, 0); set_cs(0);
    rd_word(5, w); chk("R4 array kept", w, 16'hFFFF);

    req = "R2"; cmd(9'b1_00_110000);
    req = "R1"; set_cs(1); send(4, 0); send(9, 9'b1_00_010000);
    chk("R9 oe while shifting", do_oe, 0); send(16, 16'hA5C3);
    set_cs(0); set_cs(1); tick(1);
    req = "R7"; chk("R7 busy", {do_oe, do_o}, 2'b10);
    wait_ready(n);
    chk("R6 cycle length", (n >= CYC - 6 && n <= CYC) ? 1 : 0, 1);
    chk("R7 ready", {do_oe, do_o}, 2'b11);
    req = "R8"; send_bit(1'b1); set_cs(0); set_cs(1); tick(2);
    chk("R8 cleared", do_oe, 0); set_cs(0);
    req = "R3";
    rd_word(0, w);  chk("R3 word 0", w, 16'hA5C3);
    rd_word(33, w); chk("R3 word 33", w, 16'hA5C3);
    rd_word(63, w); chk("R3 word 63", w, 16'hA5C3);

    req = "R6"; wral(16'h1234); set_cs(0);
    cmd(9'b1_00_000000);
    set_cs(1); tick(1); wait_ready(n); set_cs(0);
    wral(16'h4321); set_cs(0);
    set_cs(1); tick(1); wait_ready(n); set_cs(0);
    rd_word(7, w); chk("R6 disarm ignored while busy", w, 16'h4321);

    req = "R2"; cmd(9'b1_00_001111);
    wral(16'h0F0F); set_cs(0); tick(2);
    rd_word(20, w); chk("R2 disarmed", w, 16'h4321);

    req = "R5"; cmd(9'b1_00_111111);
    wral(16'hBEEF); tick(8); set_cs(0); set_cs(1);
    n1 = 0; n2 = 0;
    while ((do_o !== 1'b1 || do2 !== 1'b1) && n2 < 500) begin
      tick(1); n2++;
      if (do_o !== 1'b1) n1++;
    end
    chk("R5 start event order", (n2 - n1 >= 8 && n2 <= CYC) ? 1 : 0, 1);
    set_cs(0);
    rd_word(40, w); chk("R5 data", w, 16'hBEEF);

    tick(5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule